// File: doc/BRIEF.md
# Serial Flash Block Write-Lock Controller

This block is the command side of a serial flash that guards its array one 64 KB block at a time. A host talks to it over a mode-0 SPI slave port with an active-low chip select. The block oversamples the serial pins with its own system clock, shifts in opcodes and address bytes, and keeps one lock bit per block along with a small status register. The status register holds a write-enable latch and a write-in-progress flag.

A host sets the latch with a write-enable command. It can then lock a single block, or drop every lock with a chip-wide unlock. It can ask whether a given block is locked, and it can read the status register. Program and erase requests are not carried out here. They are only decoded, and the block answers each one with a one-cycle grant or deny pulse that the array sequencer downstream acts on. A lock, an unlock or a granted write keeps the block busy for a fixed number of clock cycles. While it is busy, the block refuses any further change.

Top module: `flk_ctrl`

## Requirements
- R1: After reset every lock bit is clear, and the status register reads 00h: write-enable latch at 0 and write-in-progress at 0.
- R2: Opcode 06h, ended by chip select rising on a byte boundary, sets the write-enable latch. Opcode 05h returns the status byte on every following output byte. In that byte, bit 1 is the latch, bit 0 is write-in-progress, and bits 7 to 2 read 0.
- R3: Opcode E2h followed by three address bytes locks exactly one block, provided the latch is set and the block is not busy. The block is selected by address bits 21 to 16. Address bits 23, 22 and 15 to 0 are ignored.
- R4: A lock command issued while the write-enable latch is clear changes no lock bit.
- R5: A lock command changes no lock bit and leaves the latch set if chip select rises off a byte boundary, or if it rises before all three address bytes have arrived.
- R6: Opcode FBh followed by three address bytes returns, in the first output byte, the addressed block's lock state. Bit 0 is 1 when the block is locked, and bits 7 to 1 are 0. Output bits are driven on the falling serial clock edge, most significant bit first.
- R7: Opcode F3h, ended on a byte boundary while the latch is set and the block is not busy, clears every lock bit.
- R8: A lock, an unlock or a granted write clears the latch and raises write-in-progress for BUSY_CYCLES clock cycles. During that window, lock, unlock, program and erase commands have no effect.
- R9: Program (02h) and sector erase (20h) give exactly one pulse once their third address byte is complete. The pulse is on wr_grant when the latch is set, the block is not busy and the addressed block is unlocked; otherwise it is on wr_deny. A deny leaves the latch unchanged, and a grant clears it.
- R10: The data-out enable is low whenever chip select is high, and high while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the block, sampled on the rising serial clock edge |
| spi_miso | output | 1 | Serial data out of the block, driven on the falling serial clock edge |
| spi_miso_oe | output | 1 | Drive enable for the data-out pad; the pad is high impedance when this is low |
| wr_grant | output | 1 | One-cycle pulse: program or erase request accepted |
| wr_deny | output | 1 | One-cycle pulse: program or erase request refused |

## Verification
The hardest state to reach from the pins is a command that arrives inside the busy window. Every path into that window first spends the write-enable latch, so the latch must be set again before the test command is meaningful. The bench therefore issues a lock and then, at once, a fresh write-enable. It follows these with a short unlock, or an erase, plus a status read, and it sizes the busy window so that all of these end before write-in-progress falls. Off-boundary endings are produced by appending stray bits after the address, and truncated commands by raising chip select early.

// File: rtl/flk_pkg.sv
package flk_pkg;

   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_LOCK  = 8'hE2;
   localparam logic [7:0] OP_QUERY = 8'hFB;
   localparam logic [7:0] OP_UNLK  = 8'hF3;
   localparam logic [7:0] OP_PROG  = 8'h02;
   localparam logic [7:0] OP_ERASE = 8'h20;

   // Number of bytes (opcode plus address) that make up an addressed command.
   localparam logic [2:0] ADDR_CMD_BYTES = 3'd4;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_WREN,
      CMD_RDSR,
      CMD_LOCK,
      CMD_QUERY,
      CMD_UNLK,
      CMD_WRITE
   } flk_cmd_e;

   function automatic flk_cmd_e flk_decode(input logic [7:0] op);
      flk_cmd_e c;
      case (op)
         OP_WREN:           c = CMD_WREN;
         OP_RDSR:           c = CMD_RDSR;
         OP_LOCK:           c = CMD_LOCK;
         OP_QUERY:          c = CMD_QUERY;
         OP_UNLK:           c = CMD_UNLK;
         OP_PROG, OP_ERASE: c = CMD_WRITE;
         default:           c = CMD_NONE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/flk_spi_front.sv
// Oversampling front end: synchronises the serial pins and turns them into
// single-cycle strobes in the system clock domain.
module flk_spi_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic mosi,
   output logic sel,        // chip selected (synchronised)
   output logic cs_end,     // chip select just released
   output logic rise_stb,   // serial clock rising edge while selected
   output logic fall_stb,   // serial clock falling edge while selected
   output logic rx_bit      // data bit aligned with rise_stb
);

   logic [SYNC_STAGES-1:0] cs_sr, ck_sr, di_sr;
   logic                   cs_prev, ck_prev;
   logic                   cs_s, ck_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_sr   <= '1;
         ck_sr   <= '0;
         di_sr   <= '0;
         cs_prev <= 1'b1;
         ck_prev <= 1'b0;
      end else begin
         cs_sr   <= {cs_sr[SYNC_STAGES-2:0], cs_n};
         ck_sr   <= {ck_sr[SYNC_STAGES-2:0], sclk};
         di_sr   <= {di_sr[SYNC_STAGES-2:0], mosi};
         cs_prev <= cs_s;
         ck_prev <= ck_s;
      end
   end

   assign cs_s     = cs_sr[SYNC_STAGES-1];
   assign ck_s     = ck_sr[SYNC_STAGES-1];
   assign sel      = !cs_s;
   assign cs_end   = cs_s && !cs_prev;
   assign rise_stb = sel && ck_s && !ck_prev;
   assign fall_stb = sel && !ck_s && ck_prev;
   assign rx_bit   = di_sr[SYNC_STAGES-1];

endmodule

// File: rtl/flk_rx_frame.sv
// Byte framing: bit position, saturating byte count, opcode and block index.
module flk_rx_frame #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             rise_stb,
   input  logic             rx_bit,
   output logic [2:0]       bit_idx,
   output logic [2:0]       byte_cnt,
   output logic [7:0]       opcode,
   output logic [IDX_W-1:0] blk_idx,
   output logic             byte_done
);

   logic [6:0] sh;
   logic [7:0] full_b;

   assign full_b = {sh, rx_bit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx   <= '0;
         byte_cnt  <= '0;
         opcode    <= '0;
         blk_idx   <= '0;
         sh        <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= rise_stb && (bit_idx == 3'd7);
         if (!sel) begin
            bit_idx  <= '0;
            byte_cnt <= '0;
            opcode   <= '0;
         end else if (rise_stb) begin
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) begin
               if (byte_cnt == 3'd0) opcode  <= full_b;
               if (byte_cnt == 3'd1) blk_idx <= full_b[IDX_W-1:0];
               if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 3'd1;
            end else begin
               sh <= full_b[6:0];
            end
         end
      end
   end

endmodule

// File: rtl/flk_lock_bank.sv
// One lock flop per block; set one at a time, cleared all at once.
module flk_lock_bank #(
   parameter int NUM_BLOCKS = 64,
   localparam int IDX_W     = $clog2(NUM_BLOCKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  set_en,
   input  logic [IDX_W-1:0]      set_idx,
   input  logic                  clr_all,
   output logic [NUM_BLOCKS-1:0] lock_q
);

   for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                q <= 1'b0;
         else if (clr_all)                          q <= 1'b0;
         else if (set_en && (set_idx == IDX_W'(g))) q <= 1'b1;
      end
      assign lock_q[g] = q;
   end

endmodule

// File: rtl/flk_ctrl.sv
module flk_ctrl
   import flk_pkg::*;
#(
   parameter int NUM_BLOCKS  = 64,
   parameter int BUSY_CYCLES = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sclk,
   input  logic spi_mosi,
   output logic spi_miso,
   output logic spi_miso_oe,
   output logic wr_grant,
   output logic wr_deny
);

   localparam int IDX_W  = $clog2(NUM_BLOCKS);
   localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

   if (NUM_BLOCKS < 2 || NUM_BLOCKS > 256 || (NUM_BLOCKS & (NUM_BLOCKS - 1)) != 0) begin : g_bad_blocks
      $error("NUM_BLOCKS must be a power of two between 2 and 256");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                  sel, cs_end, rise_stb, fall_stb, rx_bit;
   logic [2:0]            bit_idx, byte_cnt;
   logic [7:0]            opcode;
   logic [IDX_W-1:0]      blk;
   logic                  byte_done;
   logic [NUM_BLOCKS-1:0] lock_q;
   logic                  wel_q, busy;
   logic [BUSY_W-1:0]     busy_cnt;
   logic [7:0]            tx_byte;
   logic                  miso_q;
   flk_cmd_e              cmd;

   flk_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n),
      .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
      .sel(sel), .cs_end(cs_end), .rise_stb(rise_stb), .fall_stb(fall_stb), .rx_bit(rx_bit)
   );

   flk_rx_frame #(.IDX_W(IDX_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .sel(sel), .rise_stb(rise_stb), .rx_bit(rx_bit),
      .bit_idx(bit_idx), .byte_cnt(byte_cnt), .opcode(opcode), .blk_idx(blk),
      .byte_done(byte_done)
   );

   assign cmd = flk_decode(opcode);

   // Command completion rules
   logic on_boundary, full_addr, one_byte;
   logic set_wel, lock_go, unlk_go, wr_eval, wr_ok;

   assign on_boundary = (bit_idx == 3'd0);
   assign one_byte    = on_boundary && (byte_cnt != 3'd0);
   assign full_addr   = on_boundary && (byte_cnt >= ADDR_CMD_BYTES);

   assign set_wel = cs_end && (cmd == CMD_WREN) && one_byte;
   assign lock_go = cs_end && (cmd == CMD_LOCK) && full_addr && wel_q && !busy;
   assign unlk_go = cs_end && (cmd == CMD_UNLK) && one_byte && wel_q && !busy;
   assign wr_eval = byte_done && (cmd == CMD_WRITE) && (byte_cnt == ADDR_CMD_BYTES);
   assign wr_ok   = wr_eval && wel_q && !busy && !lock_q[blk];

   flk_lock_bank #(.NUM_BLOCKS(NUM_BLOCKS)) u_locks (
      .clk(clk), .rst_n(rst_n),
      .set_en(lock_go), .set_idx(blk), .clr_all(unlk_go),
      .lock_q(lock_q)
   );

   // Write-enable latch, busy timer and write decision pulses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q    <= 1'b0;
         busy_cnt <= '0;
         wr_grant <= 1'b0;
         wr_deny  <= 1'b0;
      end else begin
         wr_grant <= wr_ok;
         wr_deny  <= wr_eval && !wr_ok;
         if (lock_go || unlk_go || wr_ok) wel_q <= 1'b0;
         else if (set_wel)                wel_q <= 1'b1;
         if (lock_go || unlk_go || wr_ok) busy_cnt <= BUSY_W'(BUSY_CYCLES);
         else if (busy)                   busy_cnt <= busy_cnt - BUSY_W'(1);
      end
   end

   assign busy = (busy_cnt != '0);

   // Response byte, loaded as each input byte completes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_byte <= '0;
         miso_q  <= 1'b0;
      end else if (!sel) begin
         tx_byte <= '0;
         miso_q  <= 1'b0;
      end else begin
         if (byte_done) begin
            if (cmd == CMD_RDSR)
               tx_byte <= {6'b0, wel_q, busy};
            else if (cmd == CMD_QUERY && byte_cnt >= ADDR_CMD_BYTES)
               tx_byte <= {7'b0, lock_q[blk]};
            else
               tx_byte <= '0;
         end
         if (fall_stb) miso_q <= tx_byte[3'd7 - bit_idx];
      end
   end

   assign spi_miso    = miso_q;
   assign spi_miso_oe = !spi_cs_n;

endmodule

// File: rtl/flk_ctrl_chk.sv
module flk_ctrl_chk #(
   parameter int NUM_BLOCKS = 64
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_grant,
   input logic                  wr_deny,
   input logic                  wel,
   input logic                  busy,
   input logic [NUM_BLOCKS-1:0] locks
);

   // R9
   grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_grant && wr_deny));

   // R9
   deny_keeps_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_deny |=> $stable(wel));

   // R9
   grant_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant |-> !wel);

   // R8
   busy_freezes_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(locks));

   // R8
   busy_start_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !wel);

   // R4
   lock_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wel |=> ((locks & ~$past(locks)) == '0));

   // R3
   single_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(locks & ~$past(locks)) <= 1);

endmodule

bind flk_ctrl flk_ctrl_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_flk_chk (
   .clk(clk), .rst_n(rst_n), .wr_grant(wr_grant), .wr_deny(wr_deny),
   .wel(wel_q), .busy(busy), .locks(lock_q)
);

// File: tb/test_flk_ctrl.sv
module test_flk_ctrl;

   localparam int NB   = 64;
   localparam int BUSY = 1000;
   localparam int HP   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
   logic miso, miso_oe, grant, deny;

   int n_chk = 0, n_fail = 0, n_grant = 0, n_deny = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   flk_ctrl #(.NUM_BLOCKS(NB), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) i_flk_ctrl (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe), .wr_grant(grant), .wr_deny(deny)
   );

   always @(posedge clk) begin
      if (grant) n_grant++;
      if (deny)  n_deny++;
   end

   function automatic logic [7:0] exp_status(input logic wel, input logic wip);
      return {6'b0, wel, wip};
   endfunction

   function automatic logic [7:0] exp_query(input logic locked);
      return {7'b0, locked};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b, output logic o);
      mosi = b;
      repeat (HP) @(negedge clk);
      o = miso;
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic spi_cmd(input logic [7:0] op, input logic [23:0] addr, input int nbytes,
                          input int extra_bits, input int nread, output logic [7:0] rd);
      logic [7:0] b;
      logic       o;
      rd = '0;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HP) @(negedge clk);
      for (int i = 0; i < nbytes; i++) begin
         b = (i == 0) ? op : (i == 1) ? addr[23:16] : (i == 2) ? addr[15:8] : addr[7:0];
         for (int k = 7; k >= 0; k--) send_bit(b[k], o);
      end
      for (int e = 0; e < extra_bits; e++) send_bit(1'b1, o);
      for (int r = 0; r < nread; r++)
         for (int k = 7; k >= 0; k--) begin
            send_bit(1'b0, o);
            if (r == 0) rd = {rd[6:0], o};
         end
      repeat (HP) @(negedge clk);
      cs_n = 1'b1;
      repeat (2 * HP) @(negedge clk);
   endtask

   task automatic rd_status(output logic [7:0] s);
      spi_cmd(8'h05, 24'h0, 1, 0, 2, s);
   endtask

   task automatic query(input logic [23:0] addr, output logic [7:0] s);
      spi_cmd(8'hFB, addr, 4, 0, 1, s);
   endtask

   task automatic simple(input logic [7:0] op);
      logic [7:0] s;
      spi_cmd(op, 24'h0, 1, 0, 0, s);
   endtask

   task automatic wait_busy();
      repeat (BUSY + 50) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] s;
      logic       lk [NB];
      logic       wel_m;
      int         g0, d0;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NB; i++) lk[i] = 1'b0;
      wel_m = 1'b0;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state
      rd_status(s);        check("R1 status after reset", s, exp_status(0, 0));
      query(24'h00_0000, s); check("R1 block 0 unlocked", s, exp_query(0));
      query(24'h3F_0000, s); check("R1 block 63 unlocked", s, exp_query(0));
      // R10 output enable follows chip select
      check("R10 oe low while deselected", miso_oe, 1'b0);

      // R4 lock without write enable
      spi_cmd(8'hE2, 24'h05_0000, 4, 0, 0, s);
      query(24'h05_0000, s); check("R4 lock ignored without latch", s, exp_query(0));

      // R2 write enable then status
      simple(8'h06);
      rd_status(s); check("R2 latch set", s, exp_status(1, 0));

      // R3 lock with high address bits and low bits ignored; R8 busy after
      spi_cmd(8'hE2, 24'hC5_ABCD, 4, 0, 0, s);
      rd_status(s); check("R8 busy with latch cleared", s, exp_status(0, 1));
      wait_busy();
      rd_status(s); check("R8 busy ends", s, exp_status(0, 0));
      query(24'h05_0000, s); check("R3 block 5 locked", s, exp_query(1));
      query(24'h06_0000, s); check("R3 neighbour untouched", s, exp_query(0));
      query(24'h45_1234, s); check("R6 alias of block 5 reads locked", s, exp_query(1));
      lk[5] = 1'b1;

      // R5 off-boundary and truncated lock commands
      simple(8'h06);
      spi_cmd(8'hE2, 24'h09_0000, 4, 3, 0, s);
      query(24'h09_0000, s); check("R5 off-boundary lock rejected", s, exp_query(0));
      rd_status(s); check("R5 latch kept", s, exp_status(1, 0));
      spi_cmd(8'hE2, 24'h09_0000, 3, 0, 0, s);
      query(24'h09_0000, s); check("R5 truncated lock rejected", s, exp_query(0));

      // R9 program to locked block denied, latch kept
      g0 = n_grant; d0 = n_deny;
      spi_cmd(8'h02, 24'h05_0010, 4, 0, 1, s);
      check("R9 deny on locked block", n_deny - d0, 1);
      check("R9 no grant on locked block", n_grant - g0, 0);
      rd_status(s); check("R9 deny keeps latch", s, exp_status(1, 0));
      g0 = n_grant;
      spi_cmd(8'h02, 24'h07_0000, 4, 0, 1, s);
      check("R9 grant on open block", n_grant - g0, 1);
      rd_status(s); check("R9 grant clears latch", s, exp_status(0, 1));
      wait_busy();

      // R8 unlock ignored while busy
      simple(8'h06);
      spi_cmd(8'hE2, 24'h0A_0000, 4, 0, 0, s);
      simple(8'h06);
      simple(8'hF3);
      rd_status(s); check("R8 unlock ignored while busy", s, exp_status(1, 1));
      wait_busy();
      query(24'h05_0000, s); check("R8 locks survive ignored unlock", s, exp_query(1));
      lk[10] = 1'b1;

      // R8 erase denied while busy
      spi_cmd(8'hE2, 24'h0C_0000, 4, 0, 0, s);
      simple(8'h06);
      d0 = n_deny;
      spi_cmd(8'h20, 24'h0D_0000, 4, 0, 0, s);
      check("R8 erase denied while busy", n_deny - d0, 1);
      wait_busy();
      query(24'h0C_0000, s); check("R8 lock before busy applied", s, exp_query(1));
      lk[12] = 1'b1;

      // R7 chip-wide unlock
      simple(8'hF3);
      rd_status(s); check("R7 unlock clears latch", s, exp_status(0, 1));
      wait_busy();
      query(24'h05_0000, s); check("R7 block 5 cleared", s, exp_query(0));
      query(24'h0A_0000, s); check("R7 block 10 cleared", s, exp_query(0));
      query(24'h0C_0000, s); check("R7 block 12 cleared", s, exp_query(0));
      for (int i = 0; i < NB; i++) lk[i] = 1'b0;
      wel_m = 1'b0;
      check("R10 oe low after commands", miso_oe, 1'b0);

      // Random phase against the bench model
      for (int n = 0; n < 50; n++) begin
         logic [23:0] a;
         int          kind, bi;
         a    = 24'($urandom());
         bi   = int'(a[21:16]);
         kind = int'($urandom_range(0, 5));
         case (kind)
            0: begin simple(8'h06); wel_m = 1'b1; end
            1: begin
               spi_cmd(8'hE2, a, 4, 0, 0, s);
               if (wel_m) begin lk[bi] = 1'b1; wel_m = 1'b0; wait_busy(); end
            end
            2: begin
               simple(8'hF3);
               if (wel_m) begin
                  for (int i = 0; i < NB; i++) lk[i] = 1'b0;
                  wel_m = 1'b0;
                  wait_busy();
               end
            end
            3: begin
               g0 = n_grant; d0 = n_deny;
               spi_cmd(($urandom_range(0, 1) == 0) ? 8'h02 : 8'h20, a, 4, 0, 0, s);
               if (wel_m && !lk[bi]) begin
                  check("R9 random grant", n_grant - g0, 1);
                  wel_m = 1'b0;
                  wait_busy();
               end else begin
                  check("R9 random deny", n_deny - d0, 1);
               end
            end
            4: begin query(a, s); check("R6 random query", s, exp_query(lk[bi])); end
            default: begin rd_status(s); check("R2 random status", s, exp_status(wel_m, 0)); end
         endcase
      end
      for (int i = 0; i < 4; i++) begin
         query({2'b00, 6'(i * 17), 16'h0}, s);
         check("R3 final lock map", s, exp_query(lk[i * 17]));
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule